// File: doc/BRIEF.md
# Context Save Command Controller

This block is the command and status front end of a crypto engine's context save. Software first waits until the auto-status register shows the exact idle encoding. It then clears every interrupt and error status register by writing all ones to each. Finally it writes the save opcode to the first AES engine's operation register.

A save is accepted only when no engine port is carrying traffic. An accepted save holds the busy indication for a programmable number of cycles. When it finishes, the block sets done flags in two engine interrupt status registers and raises an interrupt line. A save command that arrives during port traffic is dropped, and software sees the drop because busy never appears.

An error strobe that fires during a save models a failed transfer. It leaves an error code in the first AES engine's error status register and withholds that engine's done flag. The block still returns to idle. The register bus is a plain single-cycle bus with separate read and write strobes, and read data is returned in the same cycle.

Top module: `ctxs_ctrl`

## Requirements
- R1: After reset is released, the status register (word 1) reads 0x1 (ready), all eight engine status registers (words 4 to 11) read 0, and `irq_o` is low.
- R2: Writing exactly 0x0000003C to the operation register (word 0) while idle with no port traffic makes status read 0x2 (busy) for exactly `save_cycles` cycles, with 0 treated as 1. Status then reads 0x1 again.
- R3: A save command written while any bit of `port_busy` is set is dropped: status never reads 0x2 and no status register changes. While traffic is present and no save runs, status reads 0.
- R4: A save that completes without an injected error sets bit 0 (done) in both the AES0 interrupt register (word 4) and the SHA interrupt register (word 7). The AES1 (word 5) and RSA (word 6) interrupt registers and all error registers (words 8 to 11) keep their values.
- R5: If `err_inject` is high in any cycle of a running save, including its last cycle, then the save ends with the AES0 error register (word 8) reading 0x1 and AES0 done not set. SHA done is set and status returns to 0x1.
- R6: Writing 0xFFFFFFFF to any interrupt or error status register clears it, and writing any other value to it has no effect.
- R7: `irq_o` is high exactly while at least one done bit is set, and it falls once software has cleared every set done bit.
- R8: An operation register write with any value other than the save opcode is ignored. A save opcode written while a save is running neither restarts nor lengthens that save.
- R9: When a save completes in the same cycle as a clear write to a register that completion sets, the completion wins and the register reads as set.
- R10: `err_inject` while no save is running has no effect on any status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd`, 0 otherwise |
| port_busy | input | NUM_PORTS | Traffic in progress, one bit per engine port |
| err_inject | input | 1 | Error strobe applied to a running save |
| save_cycles | input | CNT_W | Save duration in cycles |
| irq_o | output | 1 | Completion interrupt |

## Verification
Two kinds of event can land on the same clock edge: the hardware setting a done flag when a save finishes, and a software clear write to that same interrupt register. The bench counts cycles from the accepted command and times an all-ones write to AES0 so that it is sampled on the completing edge. The register must then read as set. The bench also places the error strobe on every cycle of saves of several lengths, including the final one. It judges each case by whether AES0 reports an error instead of done.

// File: rtl/ctxs_pkg.sv
// Shared constants for the context save controller: register word map,
// opcode, status encodings and engine indices.
package ctxs_pkg;
    localparam int          REG_W      = 32;
    localparam int          ADDR_W     = 4;
    localparam int          NUM_ENG    = 4;
    localparam logic [ADDR_W-1:0] A_OP   = 4'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd1;
    localparam logic [1:0]  GRP_INT    = 2'd1;   // words 4..7
    localparam logic [1:0]  GRP_ERR    = 2'd2;   // words 8..11
    localparam logic [REG_W-1:0] OPC_SAVE   = 32'h0000_003C;
    localparam logic [REG_W-1:0] CLR_ALL    = 32'hFFFF_FFFF;
    localparam logic [REG_W-1:0] STAT_READY = 32'h0000_0001;
    localparam logic [REG_W-1:0] STAT_BUSY  = 32'h0000_0002;
    localparam logic [REG_W-1:0] ERR_CODE   = 32'h0000_0001;
    typedef enum logic [1:0] {ENG_AES0 = 2'd0, ENG_AES1 = 2'd1,
                              ENG_RSA  = 2'd2, ENG_SHA  = 2'd3} eng_e;
endpackage

// File: rtl/ctxs_sequencer.sv
// Save sequencer: accepts a save command only when idle with no port
// traffic, then holds busy for save_cycles cycles (0 taken as 1).
// Assumes cmd_wr is a one-cycle qualified opcode write. fin marks the
// completing cycle; fin_err says whether an error hit this save.
module ctxs_sequencer #(
    parameter int NUM_PORTS = 4,
    parameter int CNT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic [NUM_PORTS-1:0] port_busy,
    input  logic                 err_inject,
    input  logic [CNT_W-1:0]     save_cycles,
    output logic                 busy,
    output logic                 fin,
    output logic                 fin_err
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic             err_q;
    logic             accept;

    // accept a command only when idle and all ports quiet
    assign accept  = cmd_wr && !busy_q && (port_busy == '0);
    assign fin     = busy_q && (cnt_q == ONE);
    assign fin_err = err_q || err_inject;
    assign busy    = busy_q;

    // busy window counter and error latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            err_q  <= 1'b0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= (save_cycles == '0) ? ONE : save_cycles;
            err_q  <= 1'b0;
        end else if (busy_q) begin
            if (cnt_q == ONE) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
                err_q  <= 1'b0;
            end else begin
                cnt_q  <= cnt_q - ONE;
                err_q  <= err_q || err_inject;
            end
        end
    end

    // R3
    rise_needs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> $past(port_busy == '0));
    // R2
    busy_cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q != '0));
    // R8
    no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !fin && cmd_wr) |=> (busy_q && cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/ctxs_regbank.sv
// Per-engine interrupt (done bit) and error status registers. Completion
// sets take priority over a software all-ones clear in the same cycle.
// Assumes int_sel / err_sel are at most one-hot and qualified by a write.
module ctxs_regbank
    import ctxs_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_ENG-1:0]              int_sel,
    input  logic [NUM_ENG-1:0]              err_sel,
    input  logic [REG_W-1:0]                wdata,
    input  logic                            fin,
    input  logic                            fin_err,
    output logic [NUM_ENG-1:0]              done,
    output logic [NUM_ENG-1:0][REG_W-1:0]   err
);
    logic [NUM_ENG-1:0] set_done, set_err, clr_int, clr_err;
    logic               clr_val;

    // completion set vectors and clear qualifiers
    always_comb begin
        clr_val  = (wdata == CLR_ALL);
        set_done = '0;
        set_err  = '0;
        set_done[ENG_SHA]  = fin;
        set_done[ENG_AES0] = fin && !fin_err;
        set_err[ENG_AES0]  = fin && fin_err;
        clr_int = int_sel & {NUM_ENG{clr_val}};
        clr_err = err_sel & {NUM_ENG{clr_val}};
    end

    for (genvar g = 0; g < NUM_ENG; g++) begin : g_eng
        // done flag: set wins over clear
        always_ff @(posedge clk) begin
            if (!rst_n)           done[g] <= 1'b0;
            else if (set_done[g]) done[g] <= 1'b1;
            else if (clr_int[g])  done[g] <= 1'b0;
        end

        // error code: set wins over clear
        always_ff @(posedge clk) begin
            if (!rst_n)          err[g] <= '0;
            else if (set_err[g]) err[g] <= ERR_CODE;
            else if (clr_err[g]) err[g] <= '0;
        end

        // R6
        int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (int_sel[g] && wdata == CLR_ALL && !fin) |=> !done[g]);
        // R6
        int_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (int_sel[g] && wdata != CLR_ALL && !fin) |=> $stable(done[g]));
    end

    // R4
    ok_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !fin_err) |=> (done[ENG_AES0] && done[ENG_SHA]));
    // R5
    err_blocks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && fin_err) |=> (err[ENG_AES0] != '0 && done[ENG_SHA]
                              && done[ENG_AES0] == $past(done[ENG_AES0])));
endmodule

// File: rtl/ctxs_ctrl.sv
// Context save controller top: decodes the register bus, returns read
// data combinationally, builds the status word and drives the
// completion interrupt. Word map: 0 operation, 1 status, 4..7 interrupt
// status (AES0, AES1, RSA, SHA), 8..11 error status (same order).
module ctxs_ctrl
    import ctxs_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int CNT_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    input  logic [NUM_PORTS-1:0] port_busy,
    input  logic                 err_inject,
    input  logic [CNT_W-1:0]     save_cycles,
    output logic                 irq_o
);
    logic                          cmd_wr, busy, fin, fin_err, live_q;
    logic [NUM_ENG-1:0]            int_sel, err_sel, done;
    logic [NUM_ENG-1:0][REG_W-1:0] err;
    logic [1:0]                    grp, idx;

    assign grp = bus_addr[3:2];
    assign idx = bus_addr[1:0];

    // write decode: save opcode and per-engine register selects
    always_comb begin
        cmd_wr  = bus_wr && (bus_addr == A_OP) && (bus_wdata == OPC_SAVE);
        int_sel = '0;
        err_sel = '0;
        int_sel[idx] = bus_wr && (grp == GRP_INT);
        err_sel[idx] = bus_wr && (grp == GRP_ERR);
    end

    // marks that reset has been released
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    ctxs_sequencer #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .port_busy(port_busy),
        .err_inject(err_inject), .save_cycles(save_cycles),
        .busy(busy), .fin(fin), .fin_err(fin_err));

    ctxs_regbank bank_i (
        .clk(clk), .rst_n(rst_n), .int_sel(int_sel), .err_sel(err_sel),
        .wdata(bus_wdata), .fin(fin), .fin_err(fin_err),
        .done(done), .err(err));

    // read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == A_STAT) begin
                if (busy)                                 bus_rdata = STAT_BUSY;
                else if (live_q && port_busy == '0)       bus_rdata = STAT_READY;
            end else if (grp == GRP_INT) begin
                bus_rdata = {{(REG_W-1){1'b0}}, done[idx]};
            end else if (grp == GRP_ERR) begin
                bus_rdata = err[idx];
            end
        end
    end

    // interrupt: any done bit set
    assign irq_o = |done;

    // R7
    irq_fall_by_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(bus_wr && bus_wdata == CLR_ALL && grp == GRP_INT));
    // R10
    idle_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !bus_wr) |=> $stable(err));
endmodule

// File: tb/ctxs_ctrl_tb_top.sv
module ctxs_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int CW = 8;
    localparam logic [31:0] OPC  = 32'h0000_003C;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;
    localparam logic [31:0] RDY  = 32'h1;
    localparam logic [31:0] BSY  = 32'h2;

    logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, err_inject = 0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [NP-1:0] port_busy = '0;
    logic [CW-1:0] save_cycles = '0;
    logic irq_o;
    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctxs_ctrl #(.NUM_PORTS(NP), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_busy(port_busy), .err_inject(err_inject),
        .save_cycles(save_cycles), .irq_o(irq_o));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // called at a negedge; write sampled on the next posedge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_rd = 1; bus_addr = a; #1; d = bus_rdata; bus_rd = 0;
    endtask

    task automatic clear_all();
        for (int a = 4; a < 12; a++) wr(4'(a), ONES);
    endtask

    task automatic count_busy(output int n);
        logic [31:0] s;
        n = 0;
        rd(4'd1, s);
        while (s == BSY && n < 300) begin
            n++; @(negedge clk); rd(4'd1, s);
        end
    endtask

    task automatic pulse_err();
        err_inject = 1; @(negedge clk); err_inject = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R1 reset state
        rd(4'd1, v); chk("R1 status", v, RDY);
        for (int a = 4; a < 12; a++) begin rd(4'(a), v); chk("R1 reg", v, 0); end
        chk("R1 irq", {31'b0, irq_o}, 0);

        // R2 R4 sweep over durations
        for (int c = 0; c <= 6; c++) begin
            clear_all();
            save_cycles = CW'(c);
            wr(4'd0, OPC);
            count_busy(n);
            chk("R2 busy length", n, (c == 0) ? 1 : c);
            rd(4'd1, v); chk("R2 back ready", v, RDY);
            rd(4'd4, v); chk("R4 aes0 done", v, 1);
            rd(4'd5, v); chk("R4 aes1 kept", v, 0);
            rd(4'd6, v); chk("R4 rsa kept", v, 0);
            rd(4'd7, v); chk("R4 sha done", v, 1);
            for (int a = 8; a < 12; a++) begin rd(4'(a), v); chk("R4 err zero", v, 0); end
            chk("R7 irq high", {31'b0, irq_o}, 1);
        end

        // R6 R7 clearing
        wr(4'd4, 32'h1234_5678); rd(4'd4, v); chk("R6 partial ignored", v, 1);
        wr(4'd4, ONES); rd(4'd4, v); chk("R6 aes0 cleared", v, 0);
        chk("R7 irq still sha", {31'b0, irq_o}, 1);
        wr(4'd7, ONES); rd(4'd7, v); chk("R6 sha cleared", v, 0);
        chk("R7 irq low", {31'b0, irq_o}, 0);

        // R5 error strobe at every position
        for (int c = 1; c <= 5; c++) begin
            for (int p = 0; p < c; p++) begin
                clear_all();
                save_cycles = CW'(c);
                wr(4'd0, OPC);
                repeat (p) @(negedge clk);
                pulse_err();
                count_busy(n);
                rd(4'd1, v); chk("R5 ready", v, RDY);
                rd(4'd8, v); chk("R5 aes0 err", v, 1);
                rd(4'd4, v); chk("R5 aes0 no done", v, 0);
                rd(4'd7, v); chk("R5 sha done", v, 1);
            end
        end
        wr(4'd8, 32'h0000_0001); rd(4'd8, v); chk("R6 err partial ignored", v, 1);
        wr(4'd8, ONES); rd(4'd8, v); chk("R6 err cleared", v, 0);

        // R10 idle error strobe
        clear_all();
        pulse_err(); @(negedge clk);
        for (int a = 4; a < 12; a++) begin rd(4'(a), v); chk("R10 idle inject", v, 0); end

        // R3 traffic patterns
        save_cycles = 3;
        for (int t = 1; t < (1 << NP); t++) begin
            port_busy = NP'(t);
            rd(4'd1, v); chk("R3 not ready", v, 0);
            wr(4'd0, OPC);
            for (int k = 0; k < 3; k++) begin
                rd(4'd1, v); chk("R3 no busy", v, 0); @(negedge clk);
            end
            port_busy = '0;
            rd(4'd1, v); chk("R3 ready again", v, RDY);
            rd(4'd4, v); chk("R3 no aes0", v, 0);
            rd(4'd7, v); chk("R3 no sha", v, 0);
        end

        // R8 other opcodes ignored
        for (int k = 0; k < 4; k++) begin
            logic [31:0] op;
            op = (k == 0) ? 32'h3D : (k == 1) ? 32'h0 : (k == 2) ? ONES : 32'h0100_003C;
            wr(4'd0, op);
            rd(4'd1, v); chk("R8 bad opcode", v, RDY);
        end
        rd(4'd7, v); chk("R8 no done", v, 0);
        // R8 command during busy does not restart
        save_cycles = 4;
        wr(4'd0, OPC);
        wr(4'd0, OPC);
        count_busy(n);
        chk("R8 no restart", n, 3);

        // R9 clear on the completing edge
        for (int c = 1; c <= 4; c++) begin
            clear_all();
            save_cycles = CW'(c);
            wr(4'd0, OPC);
            repeat (c - 1) @(negedge clk);
            wr(4'd4, ONES);
            rd(4'd4, v); chk("R9 set wins aes0", v, 1);
            rd(4'd1, v); chk("R9 ready", v, RDY);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule